// File: doc/BRIEF.md
# Sector Erase Window Accumulator

This block sits behind the command decoder of a flash controller and takes over once a full sector erase command sequence has been recognised. The sector named by that final write becomes the first entry of a selection mask, and a timed acceptance window opens. Every further sector-add command that arrives before the window runs out adds its own sector to the mask and restarts the window, so several sectors are erased as one batch.

When the window runs out, the block removes protected sectors from the selection. It then either pulses an erase-start strobe towards the erase engine or drops back to read mode if nothing erasable is left. While the erase runs, the block handles suspend and resume, reports the window state on the status bit the host polls, and clears itself when the engine signals that the erase is complete. The window length and the suspend latency are cycle counts set by parameters.

Top module: `sect_erase_accum`

## Requirements
- R1: After reset `sel_mask` is all zero, and `erase_start`, `q3_status`, `erasing` and `suspended` are 0.
- R2: In the idle state, a `seq_start` cycle replaces the mask with a single set bit at index `wr_addr[SECT_LSB+SECT_W-1:SECT_LSB]` and opens the window. `q3_status` reads 0 while the window is open.
- R3: While the window is open, a write with command 30h sets the addressed sector's bit and restarts the window. The window closes exactly `WIN_CYCLES` clock edges after the last accepted write, and not before.
- R4: While the window is open, a write with any command other than 30h or B0h clears the mask and returns to idle without starting an erase.
- R5: When the window closes with at least one unprotected sector selected, `erase_start` is high for exactly one cycle. In that same cycle `sel_mask` equals the selection with the `prot_mask` bits removed, and `erasing` and `q3_status` are 1.
- R6: If every selected sector is protected when the window closes, no erase starts, the mask clears and all status outputs return to 0.
- R7: While erasing, writes other than B0h and repeated `seq_start` cycles have no effect on `sel_mask` or on the state.
- R8: A B0h write while erasing raises `suspended` and lowers `erasing` exactly `SUSP_CYCLES` edges later. `q3_status` stays 1 throughout.
- R9: A B0h write while the window is open ends the window at once. `suspended` is 1 after that edge, and no erase starts while suspended.
- R10: A 30h write while suspended resumes. An erase that was already started continues without a new `erase_start`. A window that was cut short launches now, with protected sectors removed. Suspend may be issued again after a resume.
- R11: `erase_done` while erasing, or during the suspend latency, clears the mask and all status outputs. Writes other than 30h while suspended are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_start | input | 1 | Final write of a complete sector erase sequence (address on `wr_addr`) |
| wr_valid | input | 1 | Decoded host write event |
| wr_cmd | input | 8 | Command byte of the write |
| wr_addr | input | ADDR_W | Address of the write |
| prot_mask | input | 2**SECT_W | Per-sector protection, 1 = protected |
| erase_done | input | 1 | Erase engine finished |
| sel_mask | output | 2**SECT_W | Selected sectors |
| erase_start | output | 1 | One-cycle erase launch strobe |
| q3_status | output | 1 | 0 while sectors may still be added, 1 once erase has begun |
| erasing | output | 1 | Erase running (including suspend latency) |
| suspended | output | 1 | Erase suspended, reads allowed |

## Verification
Every cycle, the assertions check several properties. A launch never leaves a protected bit in the mask, and the mask does not move while an erase is running. `erasing` and `suspended` are never high together. The window counter stays inside its range, and the status bit rises only together with a launch or a suspension. Only the bench scenarios can show the exact window length after restarts, the exact suspend latency, the merged mask contents for particular sector sets, the cancel and all-protected exits, and the difference between resuming a running erase and resuming a window that was cut short.

// File: rtl/sect_pkg.sv
package sect_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_RUN   = 3'd2,
    ST_SPEND = 3'd3,
    ST_SUSP  = 3'd4
  } ctl_state_t;

  localparam logic [7:0] CMD_ADD  = 8'h30;
  localparam logic [7:0] CMD_SUSP = 8'hB0;

  typedef enum logic [1:0] {
    K_ADD   = 2'd0,
    K_SUSP  = 2'd1,
    K_OTHER = 2'd2
  } cmd_kind_t;

  function automatic cmd_kind_t classify(input logic [7:0] cmd);
    if (cmd == CMD_ADD)       return K_ADD;
    else if (cmd == CMD_SUSP) return K_SUSP;
    else                      return K_OTHER;
  endfunction
endpackage

// File: rtl/sect_cmd_decode.sv
module sect_cmd_decode
  import sect_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 12,
  parameter int SECT_W   = 7
) (
  input  logic              wr_valid,
  input  logic [7:0]        wr_cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ev_add,
  output logic              ev_susp,
  output logic              ev_other,
  output logic [SECT_W-1:0] sect_idx
);
  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[SECT_LSB +: SECT_W];
  endfunction

  cmd_kind_t kind;
  logic      unused_addr_parity;

  assign kind     = classify(wr_cmd);
  assign ev_add   = wr_valid && (kind == K_ADD);
  assign ev_susp  = wr_valid && (kind == K_SUSP);
  assign ev_other = wr_valid && (kind == K_OTHER);
  assign sect_idx = sector_of(wr_addr);
  assign unused_addr_parity = ^wr_addr;
endmodule

// File: rtl/sect_countdown.sv
module sect_countdown #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic expire
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  assign expire = armed && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= TOP;
      armed <= 1'b1;
    end else if (clear || expire) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  assert_no_early_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (CYCLES > 1)) |=> !expire);
endmodule

// File: rtl/sect_sel_mask.sv
module sect_sel_mask #(
  parameter int SECT_W = 7,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_idx,
  input  logic              prune,
  input  logic [NSECT-1:0]  prot,
  output logic [NSECT-1:0]  mask,
  output logic              eff_empty
);
  function automatic logic none_erasable(input logic [NSECT-1:0] m,
                                         input logic [NSECT-1:0] p);
    return ~|(m & ~p);
  endfunction

  assign eff_empty = none_erasable(mask, prot);

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_idx == SECT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mask[i] <= 1'b0;
      else if (clr)              mask[i] <= hit;
      else if (hit)              mask[i] <= 1'b1;
      else if (prune && prot[i]) mask[i] <= 1'b0;
    end
  end

  assert_prune_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prune |=> ((mask & $past(prot)) == '0));
  assert_clear_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_en) |=> $onehot0(mask));
endmodule

// File: rtl/sect_erase_ctrl.sv
module sect_erase_ctrl
  import sect_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seq_start,
  input  logic ev_add,
  input  logic ev_susp,
  input  logic ev_other,
  input  logic win_expire,
  input  logic susp_expire,
  input  logic erase_done,
  input  logic eff_empty,
  output logic mask_clr,
  output logic mask_set,
  output logic mask_prune,
  output logic win_load,
  output logic win_clear,
  output logic susp_load,
  output logic susp_clear,
  output logic erase_start,
  output logic erasing,
  output logic suspended,
  output logic q3_status
);
  ctl_state_t st, nxt;
  logic       launched;
  logic       launch_go;
  logic       start_q;

  always_comb begin
    nxt        = st;
    mask_clr   = 1'b0;
    mask_set   = 1'b0;
    mask_prune = 1'b0;
    win_load   = 1'b0;
    win_clear  = 1'b0;
    susp_load  = 1'b0;
    susp_clear = 1'b0;
    launch_go  = 1'b0;
    unique case (st)
      ST_IDLE: if (seq_start) begin
        mask_clr = 1'b1;
        mask_set = 1'b1;
        win_load = 1'b1;
        nxt      = ST_WIN;
      end
      ST_WIN: begin
        if (ev_add) begin
          mask_set = 1'b1;
          win_load = 1'b1;
        end else if (ev_susp) begin
          win_clear = 1'b1;
          nxt       = ST_SUSP;
        end else if (ev_other) begin
          mask_clr  = 1'b1;
          win_clear = 1'b1;
          nxt       = ST_IDLE;
        end else if (win_expire) begin
          if (eff_empty) begin
            mask_clr = 1'b1;
            nxt      = ST_IDLE;
          end else begin
            launch_go  = 1'b1;
            mask_prune = 1'b1;
            nxt        = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (erase_done) begin
          mask_clr = 1'b1;
          nxt      = ST_IDLE;
        end else if (ev_susp) begin
          susp_load = 1'b1;
          nxt       = ST_SPEND;
        end
      end
      ST_SPEND: begin
        if (erase_done) begin
          mask_clr   = 1'b1;
          susp_clear = 1'b1;
          nxt        = ST_IDLE;
        end else if (susp_expire) begin
          nxt = ST_SUSP;
        end
      end
      ST_SUSP: if (ev_add) begin
        if (launched) begin
          nxt = ST_RUN;
        end else if (eff_empty) begin
          mask_clr = 1'b1;
          nxt      = ST_IDLE;
        end else begin
          launch_go  = 1'b1;
          mask_prune = 1'b1;
          nxt        = ST_RUN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      launched <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      st      <= nxt;
      start_q <= launch_go;
      if (launch_go)                       launched <= 1'b1;
      else if (st == ST_IDLE && seq_start) launched <= 1'b0;
    end
  end

  assign erase_start = start_q;
  assign erasing     = (st == ST_RUN) || (st == ST_SPEND);
  assign suspended   = (st == ST_SUSP);
  assign q3_status   = erasing || suspended;

  assert_one_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erasing, suspended}));
  assert_q3_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q3_status) |-> (erase_start || suspended));
  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && ev_other && !ev_add && !ev_susp) |=> (!q3_status && !erase_start));
  assert_win_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && ev_susp && !ev_add) |=> (suspended && !erase_start));
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
endmodule

// File: rtl/sect_erase_accum.sv
module sect_erase_accum #(
  parameter int ADDR_W      = 19,
  parameter int SECT_LSB    = 12,
  parameter int SECT_W      = 7,
  parameter int WIN_CYCLES  = 3750,
  parameter int SUSP_CYCLES = 12500,
  localparam int NSECT      = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic              wr_valid,
  input  logic [7:0]        wr_cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              erase_done,
  output logic [NSECT-1:0]  sel_mask,
  output logic              erase_start,
  output logic              q3_status,
  output logic              erasing,
  output logic              suspended
);
  logic              ev_add, ev_susp, ev_other;
  logic [SECT_W-1:0] sect_idx;
  logic              win_expire, susp_expire;
  logic              mask_clr, mask_set, mask_prune;
  logic              win_load, win_clear, susp_load, susp_clear;
  logic              eff_empty;

  sect_cmd_decode #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)) u_dec (
    .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
    .ev_add(ev_add), .ev_susp(ev_susp), .ev_other(ev_other), .sect_idx(sect_idx)
  );

  sect_countdown #(.CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .clear(win_clear), .expire(win_expire)
  );

  sect_countdown #(.CYCLES(SUSP_CYCLES)) u_susp (
    .clk(clk), .rst_n(rst_n), .load(susp_load), .clear(susp_clear), .expire(susp_expire)
  );

  sect_sel_mask #(.SECT_W(SECT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .clr(mask_clr), .set_en(mask_set), .set_idx(sect_idx),
    .prune(mask_prune), .prot(prot_mask), .mask(sel_mask), .eff_empty(eff_empty)
  );

  sect_erase_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
    .ev_add(ev_add), .ev_susp(ev_susp), .ev_other(ev_other),
    .win_expire(win_expire), .susp_expire(susp_expire),
    .erase_done(erase_done), .eff_empty(eff_empty),
    .mask_clr(mask_clr), .mask_set(mask_set), .mask_prune(mask_prune),
    .win_load(win_load), .win_clear(win_clear),
    .susp_load(susp_load), .susp_clear(susp_clear),
    .erase_start(erase_start), .erasing(erasing),
    .suspended(suspended), .q3_status(q3_status)
  );

  assert_run_mask_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing) && !$past(erase_done)) |-> $stable(sel_mask));
  assert_start_unprotected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ((sel_mask & $past(prot_mask)) == '0 && sel_mask != '0));
endmodule

// File: tb/sect_erase_accum_test.sv
module sect_erase_accum_test;
  localparam int AW = 19;
  localparam int W  = 20;
  localparam int S  = 8;
  localparam int N  = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seq_start = 1'b0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_cmd = 8'h00;
  logic [AW-1:0] wr_addr = '0;
  logic [N-1:0]  prot_mask = '0;
  logic          erase_done = 1'b0;
  logic [N-1:0]  sel_mask;
  logic          erase_start, q3_status, erasing, suspended;

  int total = 0;
  int bad   = 0;
  int starts = 0;

  always #4 clk = ~clk;

  sect_erase_accum #(.ADDR_W(AW), .SECT_LSB(12), .SECT_W(7),
                     .WIN_CYCLES(W), .SUSP_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .wr_valid(wr_valid),
    .wr_cmd(wr_cmd), .wr_addr(wr_addr), .prot_mask(prot_mask),
    .erase_done(erase_done), .sel_mask(sel_mask), .erase_start(erase_start),
    .q3_status(q3_status), .erasing(erasing), .suspended(suspended)
  );

  always @(negedge clk) if (rst_n && erase_start) starts++;

  // vector: first sector, two added sectors, gap before second add, protected sector, protect enable
  typedef struct packed {
    logic [6:0] s0, s1, s2;
    logic [4:0] gap;
    logic [6:0] p;
    logic       pen;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{s0: 7'd3,  s1: 7'd3,   s2: 7'd3,  gap: 5'd2,  p: 7'd0,   pen: 1'b0},
    '{s0: 7'd0,  s1: 7'd127, s2: 7'd64, gap: 5'd18, p: 7'd127, pen: 1'b1},
    '{s0: 7'd5,  s1: 7'd6,   s2: 7'd7,  gap: 5'd9,  p: 7'd100, pen: 1'b1},
    '{s0: 7'd10, s1: 7'd20,  s2: 7'd30, gap: 5'd17, p: 7'd10,  pen: 1'b1}
  };

  function automatic logic [N-1:0] bit_of(input logic [6:0] s);
    logic [N-1:0] v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [6:0] s);
    return {s, 12'h5A5};
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] c, input logic [6:0] s);
    wr_valid = 1'b1; wr_cmd = c; wr_addr = addr_of(s);
    @(negedge clk);
    wr_valid = 1'b0; wr_cmd = 8'h00;
  endtask

  task automatic seq(input logic [6:0] s);
    seq_start = 1'b1; wr_addr = addr_of(s);
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic done_pulse();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int st0;
    logic [N-1:0] ex;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 mask", sel_mask, '0);
    chk("R1 status", {erase_start, q3_status, erasing, suspended}, '0);

    // table walk: accumulate, restart window, launch, complete
    foreach (VECS[k]) begin
      prot_mask = VECS[k].pen ? bit_of(VECS[k].p) : '0;
      seq(VECS[k].s0);
      chk("R2 first sector", sel_mask, bit_of(VECS[k].s0));
      chk("R2 q3 open", q3_status, 0);
      cyc(3);
      wr(8'h30, VECS[k].s1);
      cyc(int'(VECS[k].gap));
      wr(8'h30, VECS[k].s2);
      chk("R3 accumulated", sel_mask, bit_of(VECS[k].s0) | bit_of(VECS[k].s1) | bit_of(VECS[k].s2));
      cyc(W - 1);
      chk("R3 not yet launched", {erase_start, q3_status}, '0);
      cyc(1);
      ex = (bit_of(VECS[k].s0) | bit_of(VECS[k].s1) | bit_of(VECS[k].s2)) & ~prot_mask;
      chk("R5 start pulse", {erase_start, erasing, q3_status}, 3'b111);
      chk("R5 pruned mask", sel_mask, ex);
      cyc(1);
      chk("R5 single pulse", erase_start, 0);
      done_pulse();
      chk("R11 done clears mask", sel_mask, '0);
      chk("R11 done clears status", {q3_status, erasing, suspended}, '0);
    end

    // all selected protected
    prot_mask = bit_of(7'd40) | bit_of(7'd41);
    st0 = starts;
    seq(7'd40);
    wr(8'h30, 7'd41);
    cyc(W + 2);
    chk("R6 no start", 128'(starts - st0), '0);
    chk("R6 mask cleared", sel_mask, '0);
    chk("R6 idle", {q3_status, erasing, suspended}, '0);
    prot_mask = '0;

    // cancel by foreign command
    st0 = starts;
    seq(7'd33);
    cyc(2);
    wr(8'hF0, 7'd34);
    chk("R4 mask cleared", sel_mask, '0);
    chk("R4 q3 idle", q3_status, 0);
    cyc(W + 2);
    chk("R4 no start", 128'(starts - st0), '0);
    chk("R4 not erasing", erasing, 0);

    // ignore during erase, suspend latency, resume, re-suspend
    seq(7'd9);
    cyc(W);
    chk("R5 launch", erasing, 1);
    wr(8'h30, 7'd50);
    wr(8'hF0, 7'd51);
    seq(7'd52);
    chk("R7 mask frozen", sel_mask, bit_of(7'd9));
    chk("R7 still erasing", {erasing, suspended}, 2'b10);
    wr(8'hB0, 7'd0);
    cyc(S - 1);
    chk("R8 latency running", {erasing, suspended}, 2'b10);
    cyc(1);
    chk("R8 suspended", {erasing, suspended, q3_status}, 3'b011);
    wr(8'hF0, 7'd0);
    chk("R11 ignored while suspended", suspended, 1);
    st0 = starts;
    wr(8'h30, 7'd0);
    chk("R10 resumed", {erasing, suspended}, 2'b10);
    chk("R10 no new start", 128'(starts - st0), '0);
    chk("R10 mask kept", sel_mask, bit_of(7'd9));
    wr(8'hB0, 7'd0);
    cyc(S);
    chk("R10 suspend again", suspended, 1);
    wr(8'h30, 7'd0);
    done_pulse();
    chk("R11 idle after done", {sel_mask != '0, q3_status, erasing, suspended}, '0);

    // suspend inside the window
    prot_mask = bit_of(7'd13);
    st0 = starts;
    seq(7'd12);
    wr(8'h30, 7'd13);
    wr(8'hB0, 7'd0);
    chk("R9 immediate suspend", {suspended, erasing, q3_status}, 3'b101);
    cyc(W + 3);
    chk("R9 no start while suspended", 128'(starts - st0), '0);
    chk("R9 still suspended", suspended, 1);
    wr(8'h30, 7'd0);
    chk("R10 resume launches", {erase_start, erasing}, 2'b11);
    chk("R10 launch pruned", sel_mask, bit_of(7'd12));
    done_pulse();
    prot_mask = '0;

    // completion during suspend latency
    seq(7'd70);
    cyc(W);
    wr(8'hB0, 7'd0);
    cyc(2);
    done_pulse();
    chk("R11 done in latency", {sel_mask != '0, erasing, suspended}, '0);
    cyc(S + 2);
    chk("R11 no late suspend", suspended, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule